// File: doc/BRIEF.md
# Vector Schedule Length Calculator

This unit turns a compact schedule command into the two lengths a vector sequencer needs before it can issue a remapped loop. These are the active vector length (VL) and the maximum vector length (MAXVL). The command has three 5-bit dimension fields (`x_dim`, `y_dim`, `z_dim`), a 4-bit schedule selector and a vertical-first flag. The selector picks one of several schedule families: matrix multiply, FFT butterfly, DCT inner and outer butterflies, cosine-table generation, half-swap reordering and parallel tree reduction.

Most families do not get VL from one product. The unit runs a small iterative loop, one step per clock. Depending on the family, the loop counts the run of trailing ones in `x_dim`, accumulates a per-stage sum while halving an iteration count, or counts tree-reduction operations by brute force. A start pulse loads the command. A one-cycle `done` pulse marks the result, and the outputs then hold until the next accepted command.

Top module: `vsched_len_calc`

## Requirements
- R1: Selector 0b0000 (matrix) gives VL = (x_dim+1)·(y_dim+1)·(z_dim+1), kept to its low 7 bits, and MAXVL = VL.
- R2: Selectors 0b0001, 0b0100 and 0b1100 give VL = (x_dim+1)·n mod 128. Here n counts consecutive 1 bits of x_dim upward from bit 0 and is capped at 5.
- R3: Selectors 0b0011 and 0b1011 start with size=1 and it=(x_dim+1)>>1. For each trailing 1 bit of x_dim, tested from bit 0 upward with at most 5 stages, they add (it−1)·size to VL (mod 128), then double size and halve it.
- R4: Selectors 0b0101 and 0b1101 start with it=(x_dim+1)>>1. For each trailing 1 bit of x_dim, with at most 5 stages, they add it to VL (mod 128) and then halve it.
- R5: Selectors 0b0110, 0b1110 and 0b1111 give VL = x_dim+1.
- R6: Selector 0b0111 gives VL equal to the number of tree-reduction operations over N=x_dim+1 elements. The count starts with step=1. While step<N, a pointer j runs from 0 in strides of 2·step while j+step<N, and each stride is one operation. Then step doubles.
- R7: For every recognised selector other than matrix, MAXVL = VL·(z_dim+1) mod 128.
- R8: `vf_out` presents the vertical-first flag of the command that produced the current result.
- R9: Selectors 0b0010, 0b1000, 0b1001 and 0b1010 are not recognised. They give VL=0 and MAXVL=0 and still raise `done`.
- R10: `start` is accepted only while no command is in progress. A start during a run has no effect on the result.
- R11: `done` is high for exactly one cycle per accepted command, and `vl`, `maxvl` and `vf_out` change only in that cycle and hold until the next result.
- R12: After reset, `done`, `vl`, `maxvl` and `vf_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe |
| x_dim | input | 5 | First dimension field |
| y_dim | input | 5 | Second dimension field |
| z_dim | input | 5 | Third dimension / stride field |
| sched_sel | input | 4 | Schedule family selector |
| vf_in | input | 1 | Vertical-first flag |
| done | output | 1 | One-cycle result strobe |
| vl | output | 7 | Computed vector length |
| maxvl | output | 7 | Computed maximum vector length |
| vf_out | output | 1 | Vertical-first flag of the result |

## Verification
The bench builds the block with its defaults: 5-bit dimensions, 7-bit lengths and a stage cap of 5. With a 5-bit `x_dim`, the cap is reachable (x_dim=31 runs every stage), and 7-bit truncation of the products occurs often. Sweeping x_dim over all 32 values for every selector covers each trailing-ones run length and the longest reduction count (31 operations). It also covers the wrap of the matrix and scaled products. A long reduction run is used to probe a start pulse issued mid-run.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
   typedef enum logic [2:0] {
      K_MATRIX = 3'd0,
      K_TONES  = 3'd1,
      K_OUTER  = 3'd2,
      K_COS    = 3'd3,
      K_HALF   = 3'd4,
      K_REDUCE = 3'd5,
      K_NONE   = 3'd6
   } sched_kind_e;
endpackage

// File: rtl/vsched_trunc_mul.sv
module vsched_trunc_mul #(
   parameter int A_W = 6,
   parameter int B_W = 6,
   parameter int P_W = 7
) (
   input  logic [A_W-1:0] a_i,
   input  logic [B_W-1:0] b_i,
   output logic [P_W-1:0] p_o
);
   localparam int F_W = A_W + B_W;
   logic [F_W-1:0] full_w;
   assign full_w = F_W'(a_i) * F_W'(b_i);

   generate
      if (P_W <= F_W) begin : g_trunc
         assign p_o = full_w[P_W-1:0];
      end else begin : g_pad
         assign p_o = {{(P_W-F_W){1'b0}}, full_w};
      end
   endgenerate
endmodule

// File: rtl/vsched_mode_decode.sv
module vsched_mode_decode
   import vsched_pkg::*;
#(
   parameter int SEL_W = 4
) (
   input  logic [SEL_W-1:0] sel_i,
   output sched_kind_e      kind_o
);
   generate
      if (SEL_W != 4) begin : g_bad_sel
         $error("vsched_mode_decode: selector must be 4 bits");
      end
   endgenerate

   always_comb begin
      case (sel_i)
         4'b0000:                   kind_o = K_MATRIX;
         4'b0001, 4'b0100, 4'b1100: kind_o = K_TONES;
         4'b0011, 4'b1011:          kind_o = K_OUTER;
         4'b0101, 4'b1101:          kind_o = K_COS;
         4'b0110, 4'b1110, 4'b1111: kind_o = K_HALF;
         4'b0111:                   kind_o = K_REDUCE;
         default:                   kind_o = K_NONE;
      endcase
   end
endmodule

// File: rtl/vsched_iter_engine.sv
module vsched_iter_engine
   import vsched_pkg::*;
#(
   parameter int DIM_W = 5,
   parameter int VL_W  = 7,
   parameter int CAP   = 5,
   parameter int CNT_W = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  sched_kind_e      kind_i,
   input  logic [DIM_W-1:0] xd_i,
   input  logic [DIM_W-1:0] yd_i,
   input  logic [DIM_W-1:0] zd_i,
   output logic             busy_o,
   output logic             fin_o,
   output logic [VL_W-1:0]  vl_o
);
   localparam int SW  = VL_W + 1;
   localparam int D1W = DIM_W + 1;

   sched_kind_e      kind_q;
   logic [DIM_W-1:0] xd_q, yd_q, zd_q;
   logic             run_q;
   logic [CNT_W-1:0] n_q;
   logic [VL_W-1:0]  acc_q, itc_q, size_q;
   logic [SW-1:0]    step_q, j_q;

   logic [D1W-1:0]   xp1_in, xp1, yp1, zp1;
   logic [SW-1:0]    n_tot;
   logic [DIM_W-1:0] xd_shift;
   logic             stage_go;
   logic [VL_W-1:0]  mat_xy, mat_vl, tones_vl, outer_term;

   assign xp1_in   = D1W'(xd_i) + D1W'(1);
   assign xp1      = D1W'(xd_q) + D1W'(1);
   assign yp1      = D1W'(yd_q) + D1W'(1);
   assign zp1      = D1W'(zd_q) + D1W'(1);
   assign n_tot    = SW'(xp1);
   assign xd_shift = xd_q >> n_q;
   assign stage_go = (n_q < CNT_W'(CAP)) && xd_shift[0];
   assign busy_o   = run_q;

   vsched_trunc_mul #(.A_W(D1W), .B_W(D1W), .P_W(VL_W)) u_mat_xy (
      .a_i(xp1), .b_i(yp1), .p_o(mat_xy));
   vsched_trunc_mul #(.A_W(VL_W), .B_W(D1W), .P_W(VL_W)) u_mat_z (
      .a_i(mat_xy), .b_i(zp1), .p_o(mat_vl));
   vsched_trunc_mul #(.A_W(D1W), .B_W(CNT_W), .P_W(VL_W)) u_tones (
      .a_i(xp1), .b_i(n_q), .p_o(tones_vl));
   vsched_trunc_mul #(.A_W(VL_W), .B_W(VL_W), .P_W(VL_W)) u_outer (
      .a_i(itc_q - VL_W'(1)), .b_i(size_q), .p_o(outer_term));

   always_comb begin
      fin_o = 1'b0;
      vl_o  = acc_q;
      case (kind_q)
         K_MATRIX: begin fin_o = run_q;              vl_o = mat_vl;   end
         K_TONES:  begin fin_o = run_q && !stage_go; vl_o = tones_vl; end
         K_OUTER,
         K_COS:    begin fin_o = run_q && !stage_go; vl_o = acc_q;    end
         K_HALF:   begin fin_o = run_q;              vl_o = VL_W'(xp1); end
         K_REDUCE: begin fin_o = run_q && !(step_q < n_tot); vl_o = acc_q; end
         default:  begin fin_o = run_q;              vl_o = '0;       end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_NONE;
         xd_q   <= '0;
         yd_q   <= '0;
         zd_q   <= '0;
         run_q  <= 1'b0;
         n_q    <= '0;
         acc_q  <= '0;
         itc_q  <= '0;
         size_q <= '0;
         step_q <= '0;
         j_q    <= '0;
      end else if (load_i) begin
         kind_q <= kind_i;
         xd_q   <= xd_i;
         yd_q   <= yd_i;
         zd_q   <= zd_i;
         run_q  <= 1'b1;
         n_q    <= '0;
         acc_q  <= '0;
         itc_q  <= VL_W'(xp1_in >> 1);
         size_q <= VL_W'(1);
         step_q <= SW'(1);
         j_q    <= '0;
      end else if (run_q) begin
         if (fin_o) begin
            run_q <= 1'b0;
         end else begin
            case (kind_q)
               K_TONES: n_q <= n_q + CNT_W'(1);
               K_OUTER: begin
                  acc_q  <= acc_q + outer_term;
                  size_q <= size_q << 1;
                  itc_q  <= itc_q >> 1;
                  n_q    <= n_q + CNT_W'(1);
               end
               K_COS: begin
                  acc_q <= acc_q + itc_q;
                  itc_q <= itc_q >> 1;
                  n_q   <= n_q + CNT_W'(1);
               end
               K_REDUCE: begin
                  if ((j_q + step_q) < n_tot) begin
                     j_q   <= j_q + (step_q << 1);
                     acc_q <= acc_q + VL_W'(1);
                  end else begin
                     step_q <= step_q << 1;
                     j_q    <= '0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2: the trailing-ones stage counter never passes the cap
   p_stage_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      n_q <= CNT_W'(CAP));

   // R6: the reduction stride is always a power of two while running
   p_step_pow2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && kind_q == K_REDUCE) |-> ($countones(step_q) == 1));

   // R11: a finishing cycle ends the run
   p_fin_ends_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !run_q);
endmodule

// File: rtl/vsched_len_calc.sv
module vsched_len_calc
   import vsched_pkg::*;
#(
   parameter int DIM_W = 5,
   parameter int VL_W  = 7,
   parameter int SEL_W = 4,
   parameter int CAP   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIM_W-1:0] x_dim,
   input  logic [DIM_W-1:0] y_dim,
   input  logic [DIM_W-1:0] z_dim,
   input  logic [SEL_W-1:0] sched_sel,
   input  logic             vf_in,
   output logic             done,
   output logic [VL_W-1:0]  vl,
   output logic [VL_W-1:0]  maxvl,
   output logic             vf_out
);
   localparam int D1W = DIM_W + 1;

   generate
      if (VL_W < D1W) begin : g_bad_vl
         $error("vsched_len_calc: VL_W must hold x_dim+1");
      end
      if (CAP < 1 || CAP > DIM_W) begin : g_bad_cap
         $error("vsched_len_calc: CAP must lie in 1..DIM_W");
      end
   endgenerate

   sched_kind_e      kind_w, kind_q;
   logic [DIM_W-1:0] zd_q;
   logic             vf_q;
   logic             load_w, busy_w, fin_w;
   logic [VL_W-1:0]  vl_w, maxvl_w;
   logic [D1W-1:0]   scale_w;

   assign load_w = start && !busy_w;

   vsched_mode_decode #(.SEL_W(SEL_W)) u_dec (
      .sel_i(sched_sel), .kind_o(kind_w));

   vsched_iter_engine #(.DIM_W(DIM_W), .VL_W(VL_W), .CAP(CAP)) u_eng (
      .clk(clk), .rst_n(rst_n), .load_i(load_w), .kind_i(kind_w),
      .xd_i(x_dim), .yd_i(y_dim), .zd_i(z_dim),
      .busy_o(busy_w), .fin_o(fin_w), .vl_o(vl_w));

   always_comb begin
      case (kind_q)
         K_MATRIX: scale_w = D1W'(1);
         K_NONE:   scale_w = '0;
         default:  scale_w = D1W'(zd_q) + D1W'(1);
      endcase
   end

   vsched_trunc_mul #(.A_W(VL_W), .B_W(D1W), .P_W(VL_W)) u_scale (
      .a_i(vl_w), .b_i(scale_w), .p_o(maxvl_w));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= K_NONE;
         zd_q   <= '0;
         vf_q   <= 1'b0;
         done   <= 1'b0;
         vl     <= '0;
         maxvl  <= '0;
         vf_out <= 1'b0;
      end else begin
         if (load_w) begin
            kind_q <= kind_w;
            zd_q   <= z_dim;
            vf_q   <= vf_in;
         end
         done <= fin_w;
         if (fin_w) begin
            vl     <= vl_w;
            maxvl  <= maxvl_w;
            vf_out <= vf_q;
         end
      end
   end

   // R11: done is a single-cycle strobe
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: results move only together with done
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((vl != $past(vl)) || (maxvl != $past(maxvl)) || (vf_out != $past(vf_out)))
      |-> done);

   // R10: a run begins only from a start strobe
   p_accept_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_w) |-> $past(start));

   // R7: a zero length can never scale to a nonzero maximum
   p_zero_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && vl == '0) |-> (maxvl == '0));
endmodule

// File: tb/vsched_len_calc_tb_top.sv
`timescale 1ns/1ps
module vsched_len_calc_tb_top;
   localparam int DIM_W = 5;
   localparam int VL_W  = 7;
   localparam int SEL_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [DIM_W-1:0] x_dim = '0, y_dim = '0, z_dim = '0;
   logic [SEL_W-1:0] sched_sel = '0;
   logic             vf_in = 1'b0;
   logic             done;
   logic [VL_W-1:0]  vl, maxvl;
   logic             vf_out;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #2 clk = ~clk;

   vsched_len_calc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .x_dim(x_dim), .y_dim(y_dim), .z_dim(z_dim),
      .sched_sel(sched_sel), .vf_in(vf_in),
      .done(done), .vl(vl), .maxvl(maxvl), .vf_out(vf_out));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int trail_ones(input int x);
      int n = 0;
      while (n < 5 && ((x >> n) & 1) == 1) n++;
      return n;
   endfunction

   function automatic int ref_vl(input int m, input int x, input int y, input int z);
      int acc = 0, it, sz, n, st, j;
      case (m)
         0: return ((x + 1) * (y + 1) * (z + 1)) % 128;
         1, 4, 12: return ((x + 1) * trail_ones(x)) % 128;
         3, 11: begin
            sz = 1; it = (x + 1) / 2; n = trail_ones(x);
            for (int s = 0; s < n; s++) begin
               acc = (acc + (it - 1) * sz) % 128;
               sz = sz * 2; it = it / 2;
            end
            return acc;
         end
         5, 13: begin
            it = (x + 1) / 2; n = trail_ones(x);
            for (int s = 0; s < n; s++) begin
               acc = (acc + it) % 128;
               it = it / 2;
            end
            return acc;
         end
         6, 14, 15: return x + 1;
         7: begin
            st = 1;
            while (st < x + 1) begin
               j = 0;
               while (j + st < x + 1) begin j += 2 * st; acc++; end
               st = st * 2;
            end
            return acc % 128;
         end
         default: return 0;
      endcase
   endfunction

   function automatic int ref_maxvl(input int m, input int x, input int y, input int z);
      int v = ref_vl(m, x, y, z);
      if (m == 0) return v;
      if (m == 2 || m == 8 || m == 9 || m == 10) return 0;
      return (v * (z + 1)) % 128;
   endfunction

   function automatic string req_of(input int m);
      case (m)
         0: return "R1";
         1, 4, 12: return "R2";
         3, 11: return "R3";
         5, 13: return "R4";
         6, 14, 15: return "R5";
         7: return "R6";
         default: return "R9";
      endcase
   endfunction

   task automatic pulse_start(input int m, input int x, input int y, input int z, input bit vf);
      @(negedge clk);
      sched_sel = SEL_W'(m); x_dim = DIM_W'(x); y_dim = DIM_W'(y); z_dim = DIM_W'(z);
      vf_in = vf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      int t = 0;
      ok = 1'b0;
      while (t < 300) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
         t++;
      end
      if (!ok) check("R11", "done timeout", 0, 1);
   endtask

   task automatic run_and_check(input int m, input int x, input int y, input int z, input bit vf);
      bit ok;
      pulse_start(m, x, y, z, vf);
      wait_done(ok);
      if (ok) begin
         check(req_of(m), $sformatf("vl sel=%0d x=%0d", m, x), int'(vl), ref_vl(m, x, y, z));
         check((m == 0) ? "R1" : "R7", $sformatf("maxvl sel=%0d x=%0d z=%0d", m, x, z),
               int'(maxvl), ref_maxvl(m, x, y, z));
         check("R8", "vf_out", int'(vf_out), int'(vf));
      end
   endtask

   task automatic t_reset();
      check("R12", "done after reset", int'(done), 0);
      check("R12", "vl after reset", int'(vl), 0);
      check("R12", "maxvl after reset", int'(maxvl), 0);
      check("R12", "vf_out after reset", int'(vf_out), 0);
   endtask

   task automatic t_sweep(input int m);
      for (int x = 0; x < 32; x++)
         run_and_check(m, x, (x * 7 + 3) % 32, (x * 5 + m) % 32, x[0]);
   endtask

   task automatic t_corners();
      run_and_check(0, 31, 31, 31, 1'b0);   // R1 wrap: 32768 mod 128 = 0
      check("R1", "matrix full wrap", int'(vl), 0);
      run_and_check(1, 31, 0, 0, 1'b0);     // R2 cap: 32*5 mod 128 = 32
      check("R2", "tones cap", int'(vl), 32);
      run_and_check(3, 31, 0, 0, 1'b0);     // R3: 15+14+12+8+0
      check("R3", "outer full", int'(vl), 49);
      run_and_check(5, 31, 0, 0, 1'b0);     // R4: 16+8+4+2+1
      check("R4", "cos full", int'(vl), 31);
      run_and_check(7, 31, 0, 1, 1'b1);     // R6: 31 ops, R7 scale 2
      check("R6", "reduce 32", int'(vl), 31);
      check("R7", "reduce scaled", int'(maxvl), 62);
      run_and_check(7, 0, 0, 0, 1'b0);      // R6: single element, no ops
      check("R6", "reduce 1", int'(vl), 0);
   endtask

   task automatic t_busy_ignore();
      bit ok;
      pulse_start(7, 31, 0, 0, 1'b1);
      repeat (3) @(negedge clk);
      sched_sel = 4'd0; x_dim = 5'd1; y_dim = 5'd1; z_dim = 5'd1; vf_in = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (ok) begin
         check("R10", "vl after mid-run start", int'(vl), 31);
         check("R10", "vf after mid-run start", int'(vf_out), 1);
      end
   endtask

   task automatic t_done_hold();
      bit ok;
      int v, mv;
      run_and_check(6, 20, 3, 2, 1'b1);
      v = int'(vl); mv = int'(maxvl);
      @(negedge clk);
      check("R11", "done width", int'(done), 0);
      sched_sel = 4'd0; x_dim = 5'd9; z_dim = 5'd9; vf_in = 1'b0;
      repeat (6) begin
         @(negedge clk);
         check("R11", "no spurious done", int'(done), 0);
      end
      check("R11", "vl held", int'(vl), v);
      check("R11", "maxvl held", int'(maxvl), mv);
      check("R11", "vf held", int'(vf_out), 1);
      ok = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int m = 0; m < 16; m++) t_sweep(m);
      t_corners();
      t_busy_ignore();
      t_done_hold();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fails++;
         $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end
endmodule